// File: doc/BRIEF.md
# Multi-Pattern Serial Test Word Generator

This block feeds the parallel data input of a serial transmitter with a fresh test word on every accepted transfer. It produces one of six bit streams: four maximal-length pseudo-random sequences of different lengths, a fast square wave that toggles on every bit, and a slow square wave with a period of twenty bits. Each word carries W consecutive bits of the chosen serial stream, with bit 0 sent first, so that the serializer sees one unbroken stream.

A 3-bit select input picks the stream at run time. When the select changes, or on a synchronous reset, the generator reseeds its shift register and restarts the square-wave phase. The first word afterwards begins at the start of the new stream. An enable input lets the stream advance. The output side is a valid/ready stream. A word is handed over on any edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word and `out_valid` are held unchanged and the stream does not advance. When the slot is free and `en` is high, the next word appears one cycle later. When the slot is free and `en` is low, `out_valid` drops and the stream position is kept. A select change drops any pending word, even one that is being held by back-pressure.

Top module: `prbs_pattern_gen`

## Requirements
- R1: On the edge after a synchronous `rst`, `out_valid` is 0 and `out_data` is all zeros.
- R2: Select code 0 gives the stream b[k] = b[k-7] XOR b[k-6]. Bits before the restart count as 1, the first bit after the restart is b[0], and b[0] sits in `out_data` bit 0.
- R3: Select code 1 gives b[k] = b[k-15] XOR b[k-14], with the same seeding and bit order as R2.
- R4: Select code 2 gives b[k] = b[k-23] XOR b[k-18], with the same seeding and bit order as R2.
- R5: Select code 3 gives b[k] = b[k-31] XOR b[k-28], with the same seeding and bit order as R2.
- R6: Select code 4 gives b[k] = 1 when k is even and 0 when k is odd. At W=20 every word is 20'h55555.
- R7: Select code 5 gives b[k] = 1 when (k mod 20) < 10 and 0 otherwise. At W=20 every word is 20'h003FF.
- R8: Select codes 6 and 7 give all-zero words, with `out_valid` still following `en`.
- R9: On an edge where `sel` differs from its value at the previous edge, `out_valid` is 0 one cycle later and the stream restarts at k=0. Any pending word is discarded.
- R10: On an edge where the output slot is free (`out_valid` low or `out_ready` high), `out_valid` takes the value of `en`. When `en` is low the stream position is kept, so the next word continues the stream with no bits skipped.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` stay stable and no bits are consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; reseeds the generator |
| en | input | 1 | Lets the stream advance when the output slot is free |
| sel | input | 3 | Pattern code (0..3 pseudo-random, 4 fast square, 5 slow square, 6..7 zeros) |
| out_ready | input | 1 | Transmitter accepts the current word |
| out_valid | output | 1 | `out_data` holds a word of the stream |
| out_data | output | W | W consecutive stream bits, bit 0 first |

## Verification
A wrong shift-register tap, a wrong seed or a wrong bit order shows at the ports on the very first word after a restart. A wrong advance amount, such as stepping W-1 or W+1 bits, shows one word later, as a word that does not continue the reference stream. A lost or duplicated stream position around a stall or an enable gap shows in the first word after the gap. A restart that is missed on a select change shows as a valid word one cycle after the change, or as a word that does not begin the new stream. The bench computes each stream from its recurrence, bit by bit, and compares every cycle's `out_valid` and `out_data`.

// File: rtl/prbs_pattern_gen_pkg.sv
package prbs_pattern_gen_pkg;

  typedef enum logic [2:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS15 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_HALF   = 3'd4,
    PAT_SLOW   = 3'd5
  } pat_sel_e;

  localparam int NUM_PRBS   = 4;
  localparam int LFSR_MAX   = 31;
  localparam int SQ_PERIOD  = 20;

  // Register length for each pseudo-random variant.
  function automatic int prbs_len(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // Second feedback tap (first tap is always the top bit).
  function automatic int prbs_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/prbs_stepper.sv
// Advances a Fibonacci shift register W steps in one cycle.
module prbs_stepper #(
  parameter int N = 7,
  parameter int T = 6,
  parameter int W = 20
) (
  input  logic [N-1:0] state_i,
  output logic [W-1:0] word_o,
  output logic [N-1:0] state_o
);

  logic [N-1:0] walk;
  logic         fb;

  always_comb begin
    walk = state_i;
    fb   = 1'b0;
    for (int i = 0; i < W; i++) begin
      fb        = walk[N-1] ^ walk[T-1];
      word_o[i] = fb;
      walk      = {walk[N-2:0], fb};
    end
    state_o = walk;
  end

endmodule

// File: rtl/square_wave.sv
// Produces both square-wave words from a phase counter modulo the slow period.
module square_wave
  import prbs_pattern_gen_pkg::*;
#(
  parameter int W  = 20,
  parameter int PW = $clog2(SQ_PERIOD)
) (
  input  logic [PW-1:0] phase_i,
  output logic [W-1:0]  half_word_o,
  output logic [W-1:0]  slow_word_o,
  output logic [PW-1:0] phase_o
);

  localparam int unsigned ADV = W % SQ_PERIOD;

  int unsigned pos;

  always_comb begin
    pos = 0;
    for (int i = 0; i < W; i++) begin
      pos            = (32'(phase_i) + 32'(i)) % SQ_PERIOD;
      half_word_o[i] = (pos[0] == 1'b0);
      slow_word_o[i] = (pos < SQ_PERIOD / 2);
    end
    phase_o = PW'((32'(phase_i) + ADV) % SQ_PERIOD);
  end

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_pattern_gen_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   sel,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  localparam int PW = $clog2(SQ_PERIOD);

  logic [LFSR_MAX-1:0] lfsr_q;
  logic [PW-1:0]       phase_q;
  logic [PW-1:0]       phase_n;
  logic [2:0]          sel_q;

  logic [W-1:0]        prbs_word [NUM_PRBS];
  logic [LFSR_MAX-1:0] prbs_next [NUM_PRBS];
  logic [W-1:0]        half_word;
  logic [W-1:0]        slow_word;
  logic [W-1:0]        word_mux;

  logic sel_chg;
  logic slot_free;

  // One stepper per sequence length, all reading the shared register.
  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
    localparam int N = prbs_len(g);
    localparam int T = prbs_tap(g);
    logic [N-1:0] nx;

    prbs_stepper #(.N(N), .T(T), .W(W)) u_step (
      .state_i (lfsr_q[N-1:0]),
      .word_o  (prbs_word[g]),
      .state_o (nx)
    );

    assign prbs_next[g] = LFSR_MAX'(nx);
  end

  square_wave #(.W(W), .PW(PW)) u_sq (
    .phase_i     (phase_q),
    .half_word_o (half_word),
    .slow_word_o (slow_word),
    .phase_o     (phase_n)
  );

  always_comb begin
    case (pat_sel_e'(sel_q))
      PAT_PRBS7:  word_mux = prbs_word[0];
      PAT_PRBS15: word_mux = prbs_word[1];
      PAT_PRBS23: word_mux = prbs_word[2];
      PAT_PRBS31: word_mux = prbs_word[3];
      PAT_HALF:   word_mux = half_word;
      PAT_SLOW:   word_mux = slow_word;
      default:    word_mux = '0;
    endcase
  end

  assign sel_chg   = (sel != sel_q);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst || sel_chg) begin
      lfsr_q    <= '1;
      phase_q   <= '0;
      sel_q     <= sel;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (slot_free) begin
      out_valid <= en;
      if (en) begin
        out_data <= word_mux;
        lfsr_q   <= prbs_next[sel_q[1:0]];
        phase_q  <= phase_n;
      end
    end
  end

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [2:0]   sel,
  input logic         out_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data
);

  // R1
  reset_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_data == '0));

  // R11
  stall_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && sel == $past(sel)) |=> (out_valid && $stable(out_data)));

  // R10
  idle_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && (!out_valid || out_ready)) |=> !out_valid);

  // R10
  valid_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (!out_valid || out_ready) && sel == $past(sel)) |=> out_valid);

  // R9
  restart_on_select_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != $past(sel)) |=> !out_valid);

  // R8
  unused_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(sel) > 3'd5) |-> (out_data == '0));

  if (W % 2 == 0) begin : g_half
    // R6
    half_rate_word_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(sel) == 3'd4) |-> (out_data == {(W/2){2'b01}}));
  end

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .sel       (sel),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/prbs_pattern_gen_bench.sv
module prbs_pattern_gen_bench;

  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [2:0]   sel = 3'd0;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [W-1:0] out_data;

  int vectors = 0;
  int errors  = 0;

  // Reference model state
  bit           hist [0:8191];
  int           k = 0;
  int           m_sel = 0;
  logic         exp_valid = 1'b0;
  logic [W-1:0] exp_data = '0;

  always #2 clk = ~clk;

  prbs_pattern_gen #(.W(W)) u_prbs_pattern_gen (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sel       (sel),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic bit hbit(input int idx);
    if (idx < 0) return 1'b1;
    return hist[idx];
  endfunction

  // Stream bits from each pattern's definition, one at a time.
  task automatic next_word(output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      bit b;
      case (m_sel)
        0: b = hbit(k - 7)  ^ hbit(k - 6);
        1: b = hbit(k - 15) ^ hbit(k - 14);
        2: b = hbit(k - 23) ^ hbit(k - 18);
        3: b = hbit(k - 31) ^ hbit(k - 28);
        4: b = (k % 2 == 0);
        5: b = ((k % 20) < 10);
        default: b = 1'b0;
      endcase
      hist[k] = b;
      w[i] = b;
      k++;
    end
  endtask

  // Called at a falling edge: drive, model the rising edge, compare at the next fall.
  task automatic run(input bit r, input int s, input bit e, input bit rd, input string tag);
    rst = r; sel = 3'(s); en = e; out_ready = rd;
    if (r || s != m_sel) begin
      m_sel = s; k = 0; exp_valid = 1'b0; exp_data = '0;
    end else if (!exp_valid || rd) begin
      exp_valid = e;
      if (e) next_word(exp_data);
    end
    @(negedge clk);
    vectors++;
    if (out_valid !== exp_valid || out_data !== exp_data) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%05h expected valid=%0b data=%05h",
               tag, out_valid, out_data, exp_valid, exp_data);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    string tags [6];
    tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4";
    tags[3] = "R5"; tags[4] = "R6"; tags[5] = "R7";
    @(negedge clk);
    // R1: reset state
    run(1, 0, 0, 1, "R1");
    run(1, 0, 1, 1, "R1");

    // R2..R7: every pattern from restart, free-running
    for (int s = 0; s < 6; s++) begin
      run(1, s, 0, 1, "R1");
      for (int i = 0; i < 140; i++) run(0, s, 1, 1, tags[s]);
    end

    // R6 / R7: exact word values at W=20
    run(1, 4, 1, 1, "R1");
    run(0, 4, 1, 1, "R6");
    vectors++;
    if (out_data !== 20'h55555) begin
      errors++; $display("FAIL R6: data=%05h expected 55555", out_data);
    end
    run(1, 5, 1, 1, "R1");
    run(0, 5, 1, 1, "R7");
    vectors++;
    if (out_data !== 20'h003FF) begin
      errors++; $display("FAIL R7: data=%05h expected 003ff", out_data);
    end

    // R8: unused codes
    for (int s = 6; s < 8; s++) begin
      run(1, s, 0, 1, "R1");
      for (int i = 0; i < 8; i++) run(0, s, (i % 3 != 1), 1, "R8");
    end

    // R10: enable gaps keep stream position
    for (int s = 0; s < 6; s++) begin
      run(1, s, 0, 1, "R1");
      for (int i = 0; i < 60; i++) run(0, s, (i % 3 != 0), 1, "R10");
    end

    // R11: back-pressure, combined with enable gaps
    for (int s = 0; s < 6; s++) begin
      run(1, s, 0, 1, "R1");
      for (int i = 0; i < 80; i++) run(0, s, (i % 5 != 2), (i % 4 < 2), "R11");
    end

    // R9: select changes without reset, including during a stall
    run(1, 3, 1, 1, "R1");
    for (int i = 0; i < 10; i++) run(0, 3, 1, 1, "R5");
    for (int i = 0; i < 20; i++) run(0, 1, 1, 1, "R9");
    run(0, 1, 1, 0, "R11");
    for (int i = 0; i < 20; i++) run(0, 5, 1, (i % 2 == 0), "R9");
    for (int i = 0; i < 20; i++) run(0, 0, 1, 1, "R9");
    for (int i = 0; i < 8; i++) run(0, (i % 2 == 0) ? 2 : 4, 1, 1, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule